// File: doc/BRIEF.md
# Linked Multi-Channel PWM Register Bank

This block holds a bank of counter-based PWM channels. Each channel keeps a shadow copy and an active copy of its period and four compare registers. A plain register bus writes the shadow copies. Each channel's counter runs up from zero to its active period and then wraps. Its output stays high while the counter is below the active compare A value. The shadow copies move into the active copies together, either when the counter reaches the active period or when the shared sync input pulses. A sync pulse also sends every counter back to zero.

Each channel also has link fields, one for each shadowed register. A link field that names another channel makes a bus write to that register of the named channel land in the same register of this channel as well, in the same clock. This keeps a register that several channels share consistent across all of them, even when the writes race a load event. Linking reaches one level only, and it does not make different registers of one channel atomic as a group.

Top module: `pwm_link_bank`

## Requirements
- R1: After reset, every channel reads back a shadow period of PRD_RST and zero for compares A to D. Its counter is 0, its output is low, and every link field holds the channel's own index.
- R2: A write (bus_we=1) with register select 0 (period), 1 (compare A), 2 (B), 3 (C) or 4 (D) stores bus_wdata in that shadow register of channel bus_ch. bus_rdata returns shadow values combinationally for the selected channel and register.
- R3: Select 5 is link word 0, holding the link fields for period in bits [3:0], compare A in [7:4], compare B in [11:8] and compare C in [15:12]. Select 6 is link word 1, holding the compare D field in bits [3:0], with the upper bits reading 0. Both words read back what was written to that channel only.
- R4: When channel X's link field for register r holds Y, with Y not equal to X and Y below NCH, a bus write to register r of channel Y also writes the same value into register r of channel X in the same clock.
- R5: Linking reaches one level only. A write reaches the addressed channel and the channels whose field names it, and goes no further down a chain of links.
- R6: A link field equal to the channel's own index, or to a value of NCH or more, means the register is not linked.
- R7: The counter counts up by one each clock from 0 to the active period and then returns to 0, so one cycle lasts period+1 clocks.
- R8: pwm_out of a channel is 1 exactly while its counter is below its active compare A.
- R9: On the clock where the counter equals the active period, all five active registers of that channel take their shadow values. At any other time the active registers hold, except on a sync pulse.
- R10: A sync_in pulse forces the shadow-to-active load in every channel and sets every counter to 0 on the same clock edge.
- R11: If a shadow write and a load occur on the same clock, the active register takes the old shadow value. The new value stays in the shadow until the next load.
- R12: Registers within one channel are loaded from whatever their shadows hold at the load. If the period shadow was rewritten and compare A was not, the new period runs with the old compare A.
- R13: Register select 7 reads as 0, and writing to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_ch | input | CHW | Channel select |
| bus_reg | input | 3 | Register select (0 period, 1-4 compare A-D, 5-6 link words, 7 unused) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the selected channel and register |
| sync_in | input | 1 | Sync pulse: forces a load and resets all counters |
| pwm_out | output | NCH | Per-channel PWM output |

## Verification
The bench builds the bank with NCH=4, DW=16 and PRD_RST=9. Four channels are enough to form two-step link chains, and 4-bit link fields can name indices 4 to 15 that are out of range, which tests the unlinked case for invalid values. Random period and compare values are masked to five bits, so counters wrap every few clocks and loads at period end often coincide with bus writes and sync pulses. A lockstep model compares every output on every clock.

// File: rtl/pwm_link_pkg.sv
package pwm_link_pkg;

  localparam int NREG = 5;   // period + compare A..D
  localparam int LW   = 4;   // link field width

  typedef enum logic [2:0] {
    SEL_PRD  = 3'd0,
    SEL_CA   = 3'd1,
    SEL_CB   = 3'd2,
    SEL_CC   = 3'd3,
    SEL_CD   = 3'd4,
    SEL_LNK0 = 3'd5,
    SEL_LNK1 = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // A link field is live when it names another, existing channel.
  function automatic logic link_live(logic [LW-1:0] fld, int unsigned self, int unsigned nch);
    return (32'(fld) != self) && (32'(fld) < nch);
  endfunction

endpackage

// File: rtl/pwm_link_decode.sv
module pwm_link_decode
  import pwm_link_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IDX = 0,
  parameter int CHW = 2,
  parameter int DW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [CHW-1:0]       bus_ch,
  input  logic [2:0]           bus_reg,
  input  logic [DW-1:0]        bus_wdata,
  output logic [NREG-1:0]      shd_we,
  output logic [15:0]          lnk_word0,
  output logic [15:0]          lnk_word1
);

  logic [LW-1:0] fld [NREG];
  logic          own_sel;
  logic          lnk0_wr;
  logic          lnk1_wr;

  assign own_sel = (32'(bus_ch) == IDX);
  assign lnk0_wr = bus_we && own_sel && (bus_reg == SEL_LNK0);
  assign lnk1_wr = bus_we && own_sel && (bus_reg == SEL_LNK1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) fld[r] <= LW'(IDX);
    end else begin
      if (lnk0_wr) begin
        fld[0] <= bus_wdata[3:0];
        fld[1] <= bus_wdata[7:4];
        fld[2] <= bus_wdata[11:8];
        fld[3] <= bus_wdata[15:12];
      end
      if (lnk1_wr) fld[4] <= bus_wdata[3:0];
    end
  end

  // One-level fan-in: own write, or write aimed at the channel our field names.
  for (genvar r = 0; r < NREG; r++) begin : g_we
    logic live;
    assign live      = link_live(fld[r], IDX, NCH);
    assign shd_we[r] = bus_we && (bus_reg == 3'(r)) &&
                       (own_sel || (live && (32'(bus_ch) == 32'(fld[r]))));
  end

  assign lnk_word0 = {fld[3], fld[2], fld[1], fld[0]};
  assign lnk_word1 = {12'd0, fld[4]};

  // R3: link words change only through a write to this channel
  a_r3_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk0_wr |=> $stable(lnk_word0));

  // R13: select 7 never raises a shadow write enable
  a_r13_sel7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reg == SEL_NONE) |-> (shd_we == '0));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_link_pkg::*;
#(
  parameter int DW      = 16,
  parameter int PRD_RST = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          shd_we,
  input  logic [DW-1:0]            wdata,
  input  logic                     sync_in,
  output logic [NREG-1:0][DW-1:0]  shd_o,
  output logic                     pwm
);

  logic [NREG-1:0][DW-1:0] shd;
  logic [NREG-1:0][DW-1:0] act;
  logic [DW-1:0]           cnt;
  logic                    period_end;
  logic                    load_evt;

  function automatic logic [DW-1:0] next_count(logic [DW-1:0] c, logic ld);
    return ld ? '0 : c + 1'b1;
  endfunction

  function automatic logic level(logic [DW-1:0] c, logic [DW-1:0] cmp);
    return c < cmp;
  endfunction

  assign period_end = (cnt == act[SEL_PRD]);
  assign load_evt   = sync_in || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        shd[r] <= (r == 0) ? DW'(PRD_RST) : '0;
        act[r] <= (r == 0) ? DW'(PRD_RST) : '0;
      end
      cnt <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (shd_we[r]) shd[r] <= wdata;
        if (load_evt)  act[r] <= shd[r];
      end
      cnt <= next_count(cnt, load_evt);
    end
  end

  assign shd_o = shd;
  assign pwm   = level(cnt, act[SEL_CA]);

  // R9 / R11: a load copies the pre-edge shadow, never the word written alongside
  a_r9_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (act == $past(shd)));

  // R9: no load, no change in the active set
  a_r9_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act));

  // R7: counter stays within the active period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act[SEL_PRD]);

  // R10: sync returns the counter to zero
  a_r10_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (cnt == '0));

  // R2: an enabled shadow write stores the bus word
  a_r2_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
    shd_we[0] |=> (shd[0] == $past(wdata)));

endmodule

// File: rtl/pwm_link_bank.sv
module pwm_link_bank
  import pwm_link_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int PRD_RST = 9,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [CHW-1:0]   bus_ch,
  input  logic [2:0]       bus_reg,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             sync_in,
  output logic [NCH-1:0]   pwm_out
);

  logic [NREG-1:0][DW-1:0] shd_all  [NCH];
  logic [15:0]             lnk0_all [NCH];
  logic [15:0]             lnk1_all [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NREG-1:0] we_c;

    pwm_link_decode #(.NCH(NCH), .IDX(c), .CHW(CHW), .DW(DW)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_ch    (bus_ch),
      .bus_reg   (bus_reg),
      .bus_wdata (bus_wdata),
      .shd_we    (we_c),
      .lnk_word0 (lnk0_all[c]),
      .lnk_word1 (lnk1_all[c])
    );

    pwm_chan #(.DW(DW), .PRD_RST(PRD_RST)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .shd_we  (we_c),
      .wdata   (bus_wdata),
      .sync_in (sync_in),
      .shd_o   (shd_all[c]),
      .pwm     (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (32'(bus_ch) == c) begin
        case (bus_reg)
          SEL_PRD:  bus_rdata = shd_all[c][0];
          SEL_CA:   bus_rdata = shd_all[c][1];
          SEL_CB:   bus_rdata = shd_all[c][2];
          SEL_CC:   bus_rdata = shd_all[c][3];
          SEL_CD:   bus_rdata = shd_all[c][4];
          SEL_LNK0: bus_rdata = DW'(lnk0_all[c]);
          SEL_LNK1: bus_rdata = DW'(lnk1_all[c]);
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  // R13: the unused select always reads zero
  a_r13_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reg == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/pwm_link_bank_bench.sv
module pwm_link_bank_bench;

  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int PRD = 9;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_we = 1'b0;
  logic [CHW-1:0] bus_ch = '0;
  logic [2:0]     bus_reg = '0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic           sync_in = 1'b0;
  logic [NCH-1:0] pwm_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_shd [NCH][5];
  int m_act [NCH][5];
  int m_cnt [NCH];
  int m_lnk [NCH][5];

  always #10 clk = ~clk;   // 50 MHz

  pwm_link_bank #(.NCH(NCH), .DW(DW), .PRD_RST(PRD)) u_pwm_link_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_ch(bus_ch),
    .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_in(sync_in), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit live(int f, int self);
    return (f != self) && (f < NCH);
  endfunction

  function automatic int m_read(int ch, int rg);
    if (rg < 5)  return m_shd[ch][rg];
    if (rg == 5) return (m_lnk[ch][3] << 12) | (m_lnk[ch][2] << 8) |
                        (m_lnk[ch][1] << 4) | m_lnk[ch][0];
    if (rg == 6) return m_lnk[ch][4];
    return 0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NCH; i++) begin
      for (int r = 0; r < 5; r++) begin
        m_shd[i][r] = (r == 0) ? PRD : 0;
        m_act[i][r] = m_shd[i][r];
        m_lnk[i][r] = i;
      end
      m_cnt[i] = 0;
    end
  endtask

  task automatic m_step(input bit we, input int ch, input int rg, input int d, input bit sy);
    int nshd [NCH][5];
    nshd = m_shd;
    for (int i = 0; i < NCH; i++) begin
      for (int r = 0; r < 5; r++)
        if (we && rg == r && (ch == i || (live(m_lnk[i][r], i) && m_lnk[i][r] == ch)))
          nshd[i][r] = d;
      if (sy || m_cnt[i] == m_act[i][0]) begin
        for (int r = 0; r < 5; r++) m_act[i][r] = m_shd[i][r];
        m_cnt[i] = 0;
      end else begin
        m_cnt[i] = (m_cnt[i] + 1) & 16'hFFFF;
      end
    end
    if (we && rg == 5)
      for (int k = 0; k < 4; k++) m_lnk[ch][k] = (d >> (4 * k)) & 15;
    if (we && rg == 6) m_lnk[ch][4] = d & 15;
    m_shd = nshd;
  endtask

  // Called at a negedge: drive, optionally check a read, clock once, check outputs.
  task automatic step(input bit we, input int ch, input int rg, input int d,
                      input bit sy, input bit do_rd);
    bus_we = we; bus_ch = CHW'(ch); bus_reg = 3'(rg);
    bus_wdata = DW'(d); sync_in = sy;
    #1;
    if (do_rd) chk("R2 read", int'(bus_rdata), m_read(ch, rg));
    @(posedge clk);
    m_step(we, ch, rg, d, sy);
    @(negedge clk);
    bus_we = 1'b0; sync_in = 1'b0;
    for (int i = 0; i < NCH; i++)
      chk("R8 pwm", int'(pwm_out[i]), int'(m_cnt[i] < m_act[i][1]));
  endtask

  task automatic wr(input int ch, input int rg, input int d);
    step(1'b1, ch, rg, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input string tag, input int ch, input int rg, input int exp);
    bus_we = 1'b0; bus_ch = CHW'(ch); bus_reg = 3'(rg);
    #1;
    chk(tag, int'(bus_rdata), exp);
    step(1'b0, ch, rg, 0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 pwm low", int'(pwm_out), 0);
    for (int i = 0; i < NCH; i++) begin
      rd("R1 period", i, 0, PRD);
      rd("R1 cmpA", i, 1, 0);
      rd("R1 link0", i, 5, i * 16'h1111);
      rd("R1 link1", i, 6, i);
    end

    // R2: own write, no spill to an unlinked channel
    wr(2, 2, 5);
    rd("R2 own", 2, 2, 5);
    rd("R2 other", 1, 2, 0);

    // R3 / R4: ch1 period follows ch0
    wr(1, 5, 16'h1110);
    rd("R3 link0", 1, 5, 16'h1110);
    rd("R3 not ch0", 0, 5, 0);
    wr(0, 0, 7);
    rd("R4 target", 1, 0, 7);
    rd("R4 source", 0, 0, 7);

    // R5: ch2 -> ch1 -> ch0 chain, one level only
    wr(2, 5, 16'h2221);
    wr(0, 0, 6);
    rd("R5 first", 1, 0, 6);
    rd("R5 no chain", 2, 0, 9);
    wr(1, 0, 4);
    rd("R4 ch2", 2, 0, 4);
    rd("R4 no back", 0, 0, 6);

    // R6: out-of-range fields are inert
    wr(3, 5, 16'hFFFF);
    wr(3, 6, 16'h000F);
    rd("R3 link1 upper", 3, 6, 16'h000F);
    wr(0, 1, 8);
    rd("R6 cmpA", 3, 1, 0);
    wr(0, 4, 3);
    rd("R6 cmpD", 3, 4, 0);

    // R13: select 7
    wr(3, 7, 16'h1234);
    rd("R13 read", 3, 7, 0);
    rd("R13 period", 3, 0, PRD);
    rd("R13 link", 3, 5, 16'hFFFF);

    // R7 / R10: ch3 period 5, cmpA 3, loaded by sync
    wr(3, 1, 3);
    wr(3, 0, 5);
    step(1'b0, 0, 0, 0, 1'b1, 1'b0);
    chk("R10 after sync", int'(pwm_out[3]), 1);
    for (int k = 1; k < 12; k++) begin
      step(1'b0, 0, 0, 0, 1'b0, 1'b0);
      chk("R7 pattern", int'(pwm_out[3]), int'((k % 6) < 3));
    end

    // R11: write with sync in the same clock -> old shadow (5) goes active
    step(1'b1, 3, 0, 2, 1'b1, 1'b0);
    chk("R11 k0", int'(pwm_out[3]), 1);
    rd("R11 shadow", 3, 0, 2);
    for (int k = 2; k < 6; k++) begin
      step(1'b0, 0, 0, 0, 1'b0, 1'b0);
      chk("R11 old period", int'(pwm_out[3]), int'(k < 3));
    end
    // R9: load at period end brings in period 2, cmpA 3 -> always high
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 0, 0, 0, 1'b0, 1'b0);
      chk("R9 new period", int'(pwm_out[3]), 1);
    end

    // R12: new period with old compare A
    wr(3, 0, 7);
    step(1'b0, 0, 0, 0, 1'b1, 1'b0);
    chk("R12 k0", int'(pwm_out[3]), 1);
    wr(3, 1, 6);
    chk("R12 k1", int'(pwm_out[3]), 1);
    for (int k = 2; k < 8; k++) begin
      step(1'b0, 0, 0, 0, 1'b0, 1'b0);
      chk("R12 mix", int'(pwm_out[3]), int'(k < 3));
    end

    // Random phase against the lockstep model
    void'($urandom(32'hC0FFEE));
    for (int n = 0; n < 4000; n++) begin
      int rg, d;
      bit we, sy;
      we = ($urandom % 10) < 3;
      sy = ($urandom % 100) < 3;
      rg = $urandom % 8;
      d  = (rg == 5 || rg == 6) ? ($urandom & 16'hFFFF) : ($urandom & 16'h1F);
      step(we, $urandom % NCH, rg, d, sy, !we);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule